// File: doc/BRIEF.md
# Serial Flash Command Gate and Write Protection

This block sits behind the serial shift logic of a serial NOR flash and decides which received commands may change the array or the status bits. It assembles the incoming bit stream into bytes inside each chip-select frame and tracks a write-enable latch, a three-bit protect code and a lock bit for the status register. It also tracks a deep power-down state. When chip select is released it judges the complete frame. A modifying command either gets a one-cycle grant, carrying an operation code and an address for the array sequencer, or it gets a one-cycle reject.

The array sequencer answers each grant with an operation-done pulse, and that pulse clears the write-enable latch. Frames that end partway through a byte are dropped. Frames of the wrong length are dropped too, and so is anything other than the wake-up opcode while the part sleeps.

Top module: `flash_wp_ctrl`

## Requirements
- R1: A synchronous reset clears the write-enable latch, the protect code, the lock bit and deep power-down, and holds grant and reject low.
- R2: Opcode 0x06 sets the latch and 0x04 clears it. Each must be exactly one byte. The change is visible in the cycle after the first clock edge at which cs_n is sampled high after being low, and grant and reject come out at that same time.
- R3: A modifying command (0x01 status write, 0x02 page program, 0x20 sector erase, 0xD8 block erase, 0x60 or 0xC7 chip erase) that arrives while the latch is clear produces a one-cycle reject and changes no state.
- R4: An accepted modifying command produces a one-cycle grant with grant_op set to 1 page program, 2 sector, 3 block, 4 chip, 5 status write (0 when no grant). It also gives grant_addr, the low address bits of the three address bytes taken MSB first, or 0 for chip erase and status write. The latch stays set until op_done, and op_done clears it, winning over a 0x06 that ends in the same cycle.
- R5: A frame whose bit count is not a multiple of eight has no effect at all.
- R6: Length rules: 0x06, 0x04, 0xB9, 0x60 and 0xC7 need exactly 1 byte; 0x20 and 0xD8 exactly 4; 0x02 at least 4; 0x01 at least 2. A frame of any other length has no effect, and neither has an unknown opcode.
- R7: 0xB9 enters deep power-down. While in it, every frame is ignored with no grant, no reject and no state change, except 0xAB, which leaves the state.
- R8: Protect code c: 0 protects nothing, 7 the whole array, and 1 to 6 the top 2^-(7-c) of the array. A page program, sector erase or block erase is rejected when the last byte of the page, 4 KiB sector or 64 KiB block containing its address lies in the protected region.
- R9: Chip erase is rejected whenever the protect code is nonzero.
- R10: An accepted status write loads the protect code from data bits 4:2 and the lock bit from bit 7. With the lock bit set and wp_n low, a status write is rejected and leaves both unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cs_n | input | 1 | Chip select, low during a frame |
| sdi_valid | input | 1 | One serial bit present this cycle |
| sdi_bit | input | 1 | Serial bit value, MSB of each byte first |
| wp_n | input | 1 | Write-protect pin, active low |
| op_done | input | 1 | Array operation finished pulse |
| grant | output | 1 | One-cycle accept of a modifying command |
| reject | output | 1 | One-cycle refusal of a modifying command |
| grant_op | output | 3 | Kind of granted operation |
| grant_addr | output | ADDR_W | Address of granted operation |
| wel | output | 1 | Write-enable latch |
| bp | output | 3 | Protect code |
| srwd | output | 1 | Status register lock bit |
| dpd | output | 1 | Deep power-down state |

## Verification
The bench goes after the protect boundary from both sides: at code 6, a sector erase just below half the array must pass and one at the half must fail. It also checks that a block erase whose base lies below the top 1/64 but whose block reaches into it is refused, which a design testing only the start address would grant. A nine-bit enable frame and under- or over-length frames must leave the latch untouched; a design counting only bytes would set it. It covers a status write with the lock bit set under wp_n low, commands sent during deep power-down, and an op_done that coincides with an enable frame, where a wrong priority would leave the latch set.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_WRDI = 8'h04;
    localparam logic [7:0] OPC_WRSR = 8'h01;
    localparam logic [7:0] OPC_PP   = 8'h02;
    localparam logic [7:0] OPC_SE   = 8'h20;
    localparam logic [7:0] OPC_BE   = 8'hD8;
    localparam logic [7:0] OPC_CE1  = 8'h60;
    localparam logic [7:0] OPC_CE2  = 8'hC7;
    localparam logic [7:0] OPC_DP   = 8'hB9;
    localparam logic [7:0] OPC_WAKE = 8'hAB;

    typedef enum logic [2:0] {
        GOP_NONE = 3'd0,
        GOP_PROG = 3'd1,
        GOP_SECT = 3'd2,
        GOP_BLK  = 3'd3,
        GOP_CHIP = 3'd4,
        GOP_STAT = 3'd5
    } grant_op_e;

    typedef struct packed {
        logic      grant;
        logic      reject;
        logic      set_wel;
        logic      clr_wel;
        logic      wr_sr;
        logic      enter_dpd;
        logic      exit_dpd;
        grant_op_e op;
        logic [2:0] bp;
        logic      srwd;
    } action_t;

endpackage

// File: rtl/fwp_frame.sv
module fwp_frame #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sdi_valid,
    input  logic              sdi_bit,
    output logic              frame_end,
    output logic              aligned,
    output logic [2:0]        nbytes,
    output logic [7:0]        opcode,
    output logic [7:0]        sr_data,
    output logic [ADDR_W-1:0] addr
);
    logic       cs_q;
    logic [2:0] bitcnt;
    logic [6:0] shreg;
    logic [7:0] byte_c;
    logic       byte_done;

    assign byte_c    = {shreg, sdi_bit};
    assign byte_done = sdi_valid && !cs_n && (bitcnt == 3'd7);
    assign frame_end = cs_n && !cs_q;
    assign aligned   = (bitcnt == 3'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q    <= 1'b1;
            bitcnt  <= '0;
            nbytes  <= '0;
            shreg   <= '0;
            opcode  <= '0;
            sr_data <= '0;
            addr    <= '0;
        end else begin
            cs_q <= cs_n;
            if (cs_n) begin
                bitcnt <= '0;
                nbytes <= '0;
            end else if (sdi_valid) begin
                bitcnt <= bitcnt + 3'd1;
                shreg  <= byte_c[6:0];
                if (byte_done) begin
                    if (nbytes == 3'd0) opcode <= byte_c;
                    if (nbytes == 3'd1) sr_data <= byte_c;
                    if (nbytes >= 3'd1 && nbytes <= 3'd3)
                        addr <= {addr[ADDR_W-9:0], byte_c};
                    if (nbytes != 3'd7) nbytes <= nbytes + 3'd1;
                end
            end
        end
    end
endmodule

// File: rtl/fwp_decode.sv
module fwp_decode
    import flash_wp_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int PAGE_W = 8,
    parameter int SECT_W = 12,
    parameter int BLK_W  = 16
) (
    input  logic              frame_end,
    input  logic              aligned,
    input  logic [2:0]        nbytes,
    input  logic [7:0]        opcode,
    input  logic [7:0]        sr_data,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wel,
    input  logic [2:0]        bp,
    input  logic              srwd,
    input  logic              wp_n,
    input  logic              dpd,
    output action_t           act,
    output logic [ADDR_W-1:0] act_addr
);
    localparam logic [ADDR_W-1:0] PAGE_M = ADDR_W'((64'd1 << PAGE_W) - 64'd1);
    localparam logic [ADDR_W-1:0] SECT_M = ADDR_W'((64'd1 << SECT_W) - 64'd1);
    localparam logic [ADDR_W-1:0] BLK_M  = ADDR_W'((64'd1 << BLK_W) - 64'd1);

    // True when the byte at 'last' sits inside the region the code protects.
    function automatic logic in_prot(input logic [2:0] code, input logic [ADDR_W-1:0] last);
        logic [ADDR_W:0] full;
        logic [ADDR_W:0] lim;
        full = {1'b1, {ADDR_W{1'b0}}};
        lim  = full - (full >> (3'd7 - code));
        if (code == 3'd0)      return 1'b0;
        else if (code == 3'd7) return 1'b1;
        else                   return {1'b0, last} >= lim;
    endfunction

    logic one_byte;
    logic hw_lock;
    logic req;
    logic allow;
    grant_op_e kind;
    logic [ADDR_W-1:0] req_addr;

    assign one_byte = (nbytes == 3'd1);
    assign hw_lock  = srwd && !wp_n;

    always_comb begin
        act      = '0;
        act.op   = GOP_NONE;
        act_addr = '0;
        req      = 1'b0;
        allow    = 1'b0;
        kind     = GOP_NONE;
        req_addr = '0;
        if (frame_end && aligned && nbytes != 3'd0) begin
            if (dpd) begin
                act.exit_dpd = (opcode == OPC_WAKE);
            end else begin
                case (opcode)
                    OPC_WREN: act.set_wel   = one_byte;
                    OPC_WRDI: act.clr_wel   = one_byte;
                    OPC_DP:   act.enter_dpd = one_byte;
                    OPC_WRSR: begin
                        req   = (nbytes >= 3'd2);
                        allow = !hw_lock;
                        kind  = GOP_STAT;
                    end
                    OPC_PP: begin
                        req      = (nbytes >= 3'd4);
                        allow    = !in_prot(bp, addr | PAGE_M);
                        kind     = GOP_PROG;
                        req_addr = addr;
                    end
                    OPC_SE: begin
                        req      = (nbytes == 3'd4);
                        allow    = !in_prot(bp, addr | SECT_M);
                        kind     = GOP_SECT;
                        req_addr = addr;
                    end
                    OPC_BE: begin
                        req      = (nbytes == 3'd4);
                        allow    = !in_prot(bp, addr | BLK_M);
                        kind     = GOP_BLK;
                        req_addr = addr;
                    end
                    OPC_CE1, OPC_CE2: begin
                        req   = one_byte;
                        allow = (bp == 3'd0);
                        kind  = GOP_CHIP;
                    end
                    default: ;
                endcase
                if (req) begin
                    if (wel && allow) begin
                        act.grant = 1'b1;
                        act.op    = kind;
                        act_addr  = req_addr;
                        act.wr_sr = (kind == GOP_STAT);
                        act.bp    = sr_data[4:2];
                        act.srwd  = sr_data[7];
                    end else begin
                        act.reject = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/fwp_state.sv
module fwp_state
    import flash_wp_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  action_t           act,
    input  logic [ADDR_W-1:0] act_addr,
    input  logic              op_done,
    output logic              grant,
    output logic              reject,
    output logic [2:0]        grant_op,
    output logic [ADDR_W-1:0] grant_addr,
    output logic              wel,
    output logic [2:0]        bp,
    output logic              srwd,
    output logic              dpd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            grant      <= 1'b0;
            reject     <= 1'b0;
            grant_op   <= GOP_NONE;
            grant_addr <= '0;
            wel        <= 1'b0;
            bp         <= '0;
            srwd       <= 1'b0;
            dpd        <= 1'b0;
        end else begin
            grant      <= act.grant;
            reject     <= act.reject;
            grant_op   <= act.op;
            grant_addr <= act_addr;
            if (act.wr_sr) begin
                bp   <= act.bp;
                srwd <= act.srwd;
            end
            if (act.enter_dpd) dpd <= 1'b1;
            else if (act.exit_dpd) dpd <= 1'b0;
            // completion clears the latch ahead of a same-cycle enable
            if (op_done || act.clr_wel) wel <= 1'b0;
            else if (act.set_wel) wel <= 1'b1;
        end
    end
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
    import flash_wp_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int PAGE_W = 8,
    parameter int SECT_W = 12,
    parameter int BLK_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sdi_valid,
    input  logic              sdi_bit,
    input  logic              wp_n,
    input  logic              op_done,
    output logic              grant,
    output logic              reject,
    output logic [2:0]        grant_op,
    output logic [ADDR_W-1:0] grant_addr,
    output logic              wel,
    output logic [2:0]        bp,
    output logic              srwd,
    output logic              dpd
);
    logic              frame_end;
    logic              aligned;
    logic [2:0]        nbytes;
    logic [7:0]        opcode;
    logic [7:0]        sr_data;
    logic [ADDR_W-1:0] frm_addr;
    action_t           act;
    logic [ADDR_W-1:0] act_addr;

    fwp_frame #(.ADDR_W(ADDR_W)) u_frame (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sdi_valid(sdi_valid), .sdi_bit(sdi_bit),
        .frame_end(frame_end), .aligned(aligned), .nbytes(nbytes),
        .opcode(opcode), .sr_data(sr_data), .addr(frm_addr)
    );

    fwp_decode #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECT_W(SECT_W), .BLK_W(BLK_W)) u_decode (
        .frame_end(frame_end), .aligned(aligned), .nbytes(nbytes), .opcode(opcode),
        .sr_data(sr_data), .addr(frm_addr), .wel(wel), .bp(bp), .srwd(srwd),
        .wp_n(wp_n), .dpd(dpd), .act(act), .act_addr(act_addr)
    );

    fwp_state #(.ADDR_W(ADDR_W)) u_state (
        .clk(clk), .rst(rst), .act(act), .act_addr(act_addr), .op_done(op_done),
        .grant(grant), .reject(reject), .grant_op(grant_op), .grant_addr(grant_addr),
        .wel(wel), .bp(bp), .srwd(srwd), .dpd(dpd)
    );
endmodule

// File: rtl/fwp_checker.sv
module fwp_checker (
    input logic       clk,
    input logic       rst,
    input logic       wp_n,
    input logic       op_done,
    input logic       grant,
    input logic       reject,
    input logic [2:0] grant_op,
    input logic       wel,
    input logic [2:0] bp,
    input logic       srwd,
    input logic       dpd
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (!wel && !dpd && !srwd && bp == 3'd0 && !grant && !reject));

    p_grant_needs_wel_r3: assert property (@(posedge clk) disable iff (rst)
        grant |-> $past(wel));

    p_grant_code_r4: assert property (@(posedge clk) disable iff (rst)
        grant |-> (grant_op != 3'd0 && grant_op <= 3'd5));

    p_done_clears_r4: assert property (@(posedge clk) disable iff (rst)
        op_done |=> !wel);

    p_sleep_silent_r7: assert property (@(posedge clk) disable iff (rst)
        dpd |=> (!grant && !reject));

    p_chip_open_r9: assert property (@(posedge clk) disable iff (rst)
        (grant && grant_op == 3'd4) |-> $past(bp) == 3'd0);

    p_hw_lock_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(srwd) && !$past(wp_n)) |-> ($stable(bp) && $stable(srwd)));
endmodule

bind flash_wp_ctrl fwp_checker u_chk (
    .clk(clk), .rst(rst), .wp_n(wp_n), .op_done(op_done), .grant(grant),
    .reject(reject), .grant_op(grant_op), .wel(wel), .bp(bp), .srwd(srwd), .dpd(dpd)
);

// File: tb/flash_wp_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_wp_ctrl_tb_top;
    localparam int AW = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sdi_valid = 1'b0, sdi_bit = 1'b0, wp_n = 1'b1, op_done = 1'b0;
    logic grant, reject, wel, srwd, dpd;
    logic [2:0] grant_op, bp;
    logic [AW-1:0] grant_addr;

    always #2.5 clk = ~clk;

    flash_wp_ctrl #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sdi_valid(sdi_valid), .sdi_bit(sdi_bit),
        .wp_n(wp_n), .op_done(op_done), .grant(grant), .reject(reject),
        .grant_op(grant_op), .grant_addr(grant_addr), .wel(wel), .bp(bp),
        .srwd(srwd), .dpd(dpd)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic m_wel, m_dpd, m_srwd, m_grant, m_reject;
    logic [2:0] m_bp, m_op;
    logic [AW-1:0] m_addr;
    int m_nbits;
    logic [7:0] m_sh;
    logic [7:0] m_bytes[$];
    logic m_csq;

    function automatic bit m_prot(input logic [2:0] c, input int unsigned last);
        int unsigned size;
        size = 32'd1 << AW;
        if (c == 3'd0) return 1'b0;
        if (c == 3'd7) return 1'b1;
        return last >= size - size / (32'd1 << (7 - c));
    endfunction

    task automatic m_decide();
        int nb;
        bit req, ok;
        logic [2:0] kind;
        int unsigned a;
        nb = m_bytes.size();
        req = 0; ok = 0; kind = 0; a = 0;
        if (m_nbits % 8 != 0 || nb == 0) return;
        if (m_dpd) begin
            if (m_bytes[0] == 8'hAB) m_dpd = 0;
            return;
        end
        if (nb >= 4) a = {m_bytes[1], m_bytes[2], m_bytes[3]} % (32'd1 << AW);
        case (m_bytes[0])
            8'h06: if (nb == 1) m_wel = 1;
            8'h04: if (nb == 1) m_wel = 0;
            8'hB9: if (nb == 1) m_dpd = 1;
            8'h01: if (nb >= 2) begin req = 1; ok = !(m_srwd && !wp_n); kind = 5; end
            8'h02: if (nb >= 4) begin req = 1; ok = !m_prot(m_bp, a | 32'hFF); kind = 1; end
            8'h20: if (nb == 4) begin req = 1; ok = !m_prot(m_bp, a | 32'hFFF); kind = 2; end
            8'hD8: if (nb == 4) begin req = 1; ok = !m_prot(m_bp, a | 32'hFFFF); kind = 3; end
            8'h60, 8'hC7: if (nb == 1) begin req = 1; ok = (m_bp == 0); kind = 4; end
            default: ;
        endcase
        if (req) begin
            if (m_wel && ok) begin
                m_grant = 1;
                m_op = kind;
                if (kind <= 3) m_addr = a[AW-1:0];
                if (kind == 5) begin
                    m_bp = m_bytes[1][4:2];
                    m_srwd = m_bytes[1][7];
                end
            end else begin
                m_reject = 1;
            end
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        m_grant = 0; m_reject = 0; m_op = 0; m_addr = '0;
        if (rst) begin
            m_wel = 0; m_dpd = 0; m_srwd = 0; m_bp = 0;
            m_csq = 1; m_nbits = 0; m_sh = 0; m_bytes.delete();
        end else begin
            if (cs_n && !m_csq) m_decide();
            if (cs_n) begin
                m_nbits = 0;
                m_bytes.delete();
            end else if (sdi_valid) begin
                m_sh = {m_sh[6:0], sdi_bit};
                m_nbits++;
                if (m_nbits % 8 == 0) m_bytes.push_back(m_sh);
            end
            if (op_done) m_wel = 0;
            m_csq = cs_n;
        end
    end

    always @(negedge clk) begin
        if (cyc > 0) begin
            chk("R2 wel vs model", wel, m_wel);
            chk("R4 grant vs model", grant, m_grant);
            chk("R3 reject vs model", reject, m_reject);
            chk("R4 grant_op vs model", grant_op, m_op);
            chk("R4 grant_addr vs model", grant_addr, m_addr);
            chk("R10 bp vs model", bp, m_bp);
            chk("R10 srwd vs model", srwd, m_srwd);
            chk("R7 dpd vs model", dpd, m_dpd);
        end
    end

    // ---------------- stimulus ----------------
    // Called at a negedge; returns at the negedge where the decision is visible.
    task automatic frame(input logic [63:0] v, input int nb, input bit done_at_end = 1'b0);
        for (int i = nb - 1; i >= 0; i--) begin
            cs_n = 1'b0; sdi_valid = 1'b1; sdi_bit = v[i];
            @(negedge clk);
        end
        cs_n = 1'b1; sdi_valid = 1'b0; op_done = done_at_end;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    task automatic pulse_done();
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 wel after reset", wel, 0);
        chk("R1 dpd after reset", dpd, 0);
        chk("R1 bp after reset", bp, 0);
        chk("R1 srwd after reset", srwd, 0);
        chk("R1 grant after reset", grant, 0);

        frame(64'h02_000100_AA, 40);
        chk("R3 reject without latch", reject, 1);
        chk("R3 no grant without latch", grant, 0);

        frame(64'h06, 8);
        chk("R2 enable sets latch", wel, 1);
        frame(64'h04, 8);
        chk("R2 disable clears latch", wel, 0);

        frame(64'h06, 8);
        frame(64'h02_000100_AA, 40);
        chk("R4 program grant", grant, 1);
        chk("R4 program op", grant_op, 1);
        chk("R4 program addr", grant_addr, 32'h00100);
        chk("R4 latch held until done", wel, 1);
        pulse_done();
        chk("R4 done clears latch", wel, 0);

        frame(64'h00C, 9);
        chk("R5 nine-bit enable ignored", wel, 0);

        frame(64'h0606, 16);
        chk("R6 two-byte enable ignored", wel, 0);
        frame(64'h06, 8);
        frame(64'h20_0F00, 24);
        chk("R6 short erase no reject", reject, 0);
        chk("R6 short erase no grant", grant, 0);
        frame(64'h20_0F0000_00, 40);
        chk("R6 long erase no reject", reject, 0);
        chk("R6 latch kept", wel, 1);
        frame(64'h04, 8);

        frame(64'h06, 8);
        frame(64'h01_04, 16);
        chk("R10 status write grant", grant, 1);
        chk("R10 status write op", grant_op, 5);
        chk("R10 bp loaded", bp, 1);
        pulse_done();

        frame(64'h06, 8);
        frame(64'h20_0FF000, 32);
        chk("R8 top sector refused", reject, 1);
        chk("R8 latch kept on refusal", wel, 1);
        frame(64'h20_0F0000, 32);
        chk("R8 lower sector granted", grant, 1);
        chk("R8 sector op", grant_op, 2);
        pulse_done();

        frame(64'h06, 8);
        frame(64'hD8_0F0000, 32);
        chk("R8 block reaching region refused", reject, 1);
        frame(64'hC7, 8);
        chk("R9 chip erase refused", reject, 1);
        frame(64'h60, 8);
        chk("R9 alt chip erase refused", reject, 1);
        frame(64'h04, 8);

        frame(64'h06, 8);
        frame(64'h01_18, 16);
        chk("R10 bp six", bp, 6);
        pulse_done();
        frame(64'h06, 8);
        frame(64'h20_080000, 32);
        chk("R8 half boundary refused", reject, 1);
        frame(64'h20_07F000, 32);
        chk("R8 below half granted", grant, 1);
        pulse_done();

        frame(64'h06, 8);
        frame(64'h01_80, 16);
        chk("R10 lock set", srwd, 1);
        chk("R10 bp cleared", bp, 0);
        pulse_done();
        wp_n = 1'b0;
        frame(64'h06, 8);
        frame(64'h01_1C, 16);
        chk("R10 locked write refused", reject, 1);
        chk("R10 bp unchanged", bp, 0);
        chk("R10 lock unchanged", srwd, 1);
        frame(64'h04, 8);
        wp_n = 1'b1;
        frame(64'h06, 8);
        frame(64'h01_00, 16);
        chk("R10 unlocked write granted", grant, 1);
        chk("R10 lock cleared", srwd, 0);
        pulse_done();

        frame(64'h06, 8);
        frame(64'hC7, 8);
        chk("R9 chip erase granted", grant, 1);
        chk("R9 chip op", grant_op, 4);
        pulse_done();

        frame(64'h06, 8);
        frame(64'hB9, 8);
        chk("R7 sleep entered", dpd, 1);
        frame(64'h02_000100_AA, 40);
        chk("R7 program ignored no grant", grant, 0);
        chk("R7 program ignored no reject", reject, 0);
        frame(64'h04, 8);
        chk("R7 disable ignored", wel, 1);
        frame(64'hAB, 8);
        chk("R7 wake", dpd, 0);
        frame(64'h04, 8);
        chk("R2 disable after wake", wel, 0);

        frame(64'h06, 8, 1'b1);
        chk("R4 done beats enable", wel, 0);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule